// File: doc/BRIEF.md
# Start/Done Handshake Sum Core

This block is a small arithmetic core placed behind a block-level start/done handshake. Each run takes two unsigned scalar operands and one operand that is both read and written. That read-write operand is split into a plain input with no handshake and a separate output with its own one-cycle valid strobe. A run produces two results. The updated sum is both scalars plus the read-write input. The return value is the sum of the two scalars only, and it is held in a register.

A controller starts the run when `start` is sampled high. The run then moves through a fixed sequence of phases. Each phase is reported on its own output: `idle` is a level, and `ready`, the sum valid strobe and `done` are single-cycle pulses in consecutive cycles. Three parameters choose the variant:

- `CAPTURE` chooses whether the scalar operands are captured once, in the first cycle after start, or read live in the ready cycle.
- `FREE_RUN` removes the block-level control altogether. The core then recomputes on every clock.
- `DW` sets the operand width.

Top module: `sumcore_top`

## Requirements
- R1: While reset is high and in the cycle after it, `idle` is 1 (handshake mode only), `ready`, `done` and `acc_vld` are 0, and `acc_out` and `result` are 0.
- R2: A run begins only when `start` is sampled high at a rising edge while `idle` is 1. `idle` is 0 from the cycle after that edge until the run ends. With `start` low, the core stays idle and `ready` stays 0.
- R3: Counting the start-sampling edge as edge 0, `ready` is 1 for exactly the one cycle that follows edge 1.
- R4: `acc_vld` is 1 for exactly the one cycle after edge 2. In that cycle `acc_out` equals `(a + b + acc_in) mod 2^(DW+2)`. `acc_out` holds that value until the next computation.
- R5: `done` is 1 for exactly the one cycle after edge 3. In that cycle `result` equals `a + b`, exact in DW+1 bits. `result` holds that value until the next computation.
- R6: If `start` is low at edge 4, `idle` returns to 1 in the cycle after edge 4.
- R7: If `start` is high at edge 4 (during the done cycle), edge 4 becomes edge 0 of the next run, and `idle` stays 0.
- R8: With `CAPTURE`=1, the operands `a`, `b` and `acc_in` are the port values sampled at edge 1. Later changes during the run have no effect on `acc_out` or `result`.
- R9: With `CAPTURE`=0, the operands are the port values sampled at edge 2, at the end of the ready cycle.
- R10: With `FREE_RUN`=1, `start` is ignored and `done`, `ready` and `idle` stay 0. After each edge, `acc_out` and `result` reflect the inputs sampled at that edge, and `acc_vld` is 1 from the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a run |
| in_a | input | DW | First scalar operand (unsigned) |
| in_b | input | DW | Second scalar operand (unsigned) |
| acc_in | input | DW+2 | Read side of the read-write operand, no handshake |
| acc_out | output | DW+2 | Write side of the read-write operand, registered |
| acc_vld | output | 1 | One-cycle strobe marking a new `acc_out` |
| result | output | DW+1 | Registered return value `a + b` |
| done | output | 1 | One-cycle pulse at run completion; qualifies `result` |
| ready | output | 1 | One-cycle pulse once all operands are consumed |
| idle | output | 1 | High while waiting for a start |

## Verification
The bench runs three small instances, each with 3-bit operands:

- **Capture instance.** It is swept over every pair of scalar operands, combined with several read-write values. During each run the inputs are switched to a different set right after edge 1. Those results therefore separate operands taken at edge 1 from operands taken at edge 2, which tells the capture variant apart from the live one.
- **Live instance.** The same sweep checks that it follows the second set.
- **Back-to-back runs.** With `start` held high through the done cycle, the bench confirms that `idle` never rises and that the pulse timing repeats.
- **Free-running instance.** It is driven with an exhaustive operand sweep while `start` toggles. Its outputs must trail the inputs by exactly one edge, including wrap-around of the truncated sum, while the control outputs stay low.

// File: rtl/sumcore_pkg.sv
package sumcore_pkg;

    // Run phases of the block-level handshake; order is the run sequence.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CAP  = 3'd1,
        PH_ADD  = 3'd2,
        PH_OUT  = 3'd3,
        PH_DONE = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e phase;
    } ctrl_regs_t;

endpackage

// File: rtl/sumcore_ctrl.sv
module sumcore_ctrl
    import sumcore_pkg::*;
#(
    parameter bit FREE_RUN = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic cap_en,
    output logic calc_en,
    output logic done,
    output logic ready,
    output logic idle
);

    ctrl_regs_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.phase)
            PH_IDLE: if (start && !FREE_RUN) ctl_d.phase = PH_CAP;
            PH_CAP:  ctl_d.phase = PH_ADD;
            PH_ADD:  ctl_d.phase = PH_OUT;
            PH_OUT:  ctl_d.phase = PH_DONE;
            PH_DONE: ctl_d.phase = start ? PH_CAP : PH_IDLE;
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{phase: PH_IDLE};
        else     ctl_q <= ctl_d;
    end

    always_comb begin
        cap_en  = !FREE_RUN && (ctl_q.phase == PH_CAP);
        calc_en = FREE_RUN  || (ctl_q.phase == PH_ADD);
        ready   = !FREE_RUN && (ctl_q.phase == PH_ADD);
        done    = !FREE_RUN && (ctl_q.phase == PH_DONE);
        idle    = !FREE_RUN && (ctl_q.phase == PH_IDLE);
    end

    generate
        if (!FREE_RUN) begin : g_hs_checks
            // R2: a sampled start in idle leaves idle on the next cycle
            p_start_leaves_idle_r2: assert property (@(posedge clk) disable iff (rst)
                idle && start |=> !idle);
            // R3: ready is a single-cycle pulse
            p_ready_pulse_r3: assert property (@(posedge clk) disable iff (rst)
                ready |=> !ready);
            // R5: done arrives two cycles after ready
            p_ready_to_done_r5: assert property (@(posedge clk) disable iff (rst)
                ready |=> ##1 done);
            // R7: start during done chains straight into a capture phase
            p_chain_r7: assert property (@(posedge clk) disable iff (rst)
                done && start |=> !idle && cap_en);
        end
    endgenerate

endmodule

// File: rtl/sumcore_capture.sv
module sumcore_capture #(
    parameter int DW = 8,
    localparam int SW = DW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [SW-1:0] c_i,
    output logic [DW-1:0] a_o,
    output logic [DW-1:0] b_o,
    output logic [SW-1:0] c_o
);

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [SW-1:0] c;
    } cap_regs_t;

    cap_regs_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (load) begin
            cap_d.a = a_i;
            cap_d.b = b_i;
            cap_d.c = c_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else     cap_q <= cap_d;
    end

    assign a_o = cap_q.a;
    assign b_o = cap_q.b;
    assign c_o = cap_q.c;

    // R8: captured operands do not move outside the capture cycle
    p_hold_operands_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(a_o) && $stable(b_o) && $stable(c_o));

endmodule

// File: rtl/sumcore_datapath.sv
module sumcore_datapath #(
    parameter int DW = 8,
    localparam int SW = DW + 2,
    localparam int RW = DW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [SW-1:0] c,
    output logic [SW-1:0] sum_o,
    output logic          sum_vld,
    output logic [RW-1:0] ret_o
);

    typedef struct packed {
        logic [SW-1:0] sum;
        logic [RW-1:0] ret;
        logic          vld;
    } dp_regs_t;

    dp_regs_t dp_d, dp_q;
    logic [RW-1:0] pair_sum;

    always_comb begin
        pair_sum = RW'(a) + RW'(b);
        dp_d     = dp_q;
        dp_d.vld = load;
        if (load) begin
            dp_d.ret = pair_sum;
            dp_d.sum = SW'(pair_sum) + c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dp_q <= '0;
        else     dp_q <= dp_d;
    end

    assign sum_o   = dp_q.sum;
    assign sum_vld = dp_q.vld;
    assign ret_o   = dp_q.ret;

    // R4: the updated sum holds between computations
    p_sum_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(sum_o));
    // R5: the return register holds between computations
    p_ret_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ret_o));

endmodule

// File: rtl/sumcore_top.sv
module sumcore_top #(
    parameter int DW       = 8,
    parameter bit CAPTURE  = 1'b1,
    parameter bit FREE_RUN = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic [DW+1:0] acc_in,
    output logic [DW+1:0] acc_out,
    output logic          acc_vld,
    output logic [DW:0]   result,
    output logic          done,
    output logic          ready,
    output logic          idle
);

    localparam int SW = DW + 2;

    logic          cap_en;
    logic          calc_en;
    logic [DW-1:0] op_a;
    logic [DW-1:0] op_b;
    logic [SW-1:0] op_c;

    sumcore_ctrl #(.FREE_RUN(FREE_RUN)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cap_en  (cap_en),
        .calc_en (calc_en),
        .done    (done),
        .ready   (ready),
        .idle    (idle)
    );

    generate
        if (CAPTURE && !FREE_RUN) begin : g_capture
            sumcore_capture #(.DW(DW)) u_cap (
                .clk  (clk),
                .rst  (rst),
                .load (cap_en),
                .a_i  (in_a),
                .b_i  (in_b),
                .c_i  (acc_in),
                .a_o  (op_a),
                .b_o  (op_b),
                .c_o  (op_c)
            );
        end else begin : g_live
            logic unused_cap;
            assign unused_cap = cap_en;
            assign op_a = in_a;
            assign op_b = in_b;
            assign op_c = acc_in;
        end
    endgenerate

    sumcore_datapath #(.DW(DW)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .load    (calc_en),
        .a       (op_a),
        .b       (op_b),
        .c       (op_c),
        .sum_o   (acc_out),
        .sum_vld (acc_vld),
        .ret_o   (result)
    );

    generate
        if (FREE_RUN) begin : g_free_checks
            // R10: no block-level control activity in free-running mode
            p_quiet_ctrl_r10: assert property (@(posedge clk) disable iff (rst)
                !done && !ready && !idle);
        end else begin : g_hs_top_checks
            // R5: the sum strobe is followed by done on the next cycle
            p_vld_then_done_r5: assert property (@(posedge clk) disable iff (rst)
                acc_vld |=> done);
            // R4: the sum strobe is a single-cycle pulse
            p_vld_pulse_r4: assert property (@(posedge clk) disable iff (rst)
                acc_vld |=> !acc_vld);
            // R2: idle and the phase pulses never overlap
            p_idle_excl_r2: assert property (@(posedge clk) disable iff (rst)
                idle |-> !done && !ready && !acc_vld);
        end
    endgenerate

endmodule

// File: tb/sumcore_top_test.sv
module sumcore_top_test;

    localparam int DW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // shared stimulus for the two handshake instances
    logic          st_c = 1'b0, st_l = 1'b0;
    logic [DW-1:0] ha = '0, hb = '0;
    logic [DW+1:0] hc = '0;
    // free-running instance stimulus
    logic          fs = 1'b0;
    logic [DW-1:0] fa = '0, fb = '0;
    logic [DW+1:0] fc = '0;

    logic [DW+1:0] c_sum, l_sum, f_sum;
    logic [DW:0]   c_ret, l_ret, f_ret;
    logic c_vld, c_done, c_rdy, c_idle;
    logic l_vld, l_done, l_rdy, l_idle;
    logic f_vld, f_done, f_rdy, f_idle;

    sumcore_top #(.DW(DW), .CAPTURE(1'b1), .FREE_RUN(1'b0)) uut (
        .clk(clk), .rst(rst), .start(st_c), .in_a(ha), .in_b(hb), .acc_in(hc),
        .acc_out(c_sum), .acc_vld(c_vld), .result(c_ret),
        .done(c_done), .ready(c_rdy), .idle(c_idle));

    sumcore_top #(.DW(DW), .CAPTURE(1'b0), .FREE_RUN(1'b0)) uut_live (
        .clk(clk), .rst(rst), .start(st_l), .in_a(ha), .in_b(hb), .acc_in(hc),
        .acc_out(l_sum), .acc_vld(l_vld), .result(l_ret),
        .done(l_done), .ready(l_rdy), .idle(l_idle));

    sumcore_top #(.DW(DW), .CAPTURE(1'b1), .FREE_RUN(1'b1)) uut_free (
        .clk(clk), .rst(rst), .start(fs), .in_a(fa), .in_b(fb), .acc_in(fc),
        .acc_out(f_sum), .acc_vld(f_vld), .result(f_ret),
        .done(f_done), .ready(f_rdy), .idle(f_idle));

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_sum(input int a, input int b, input int c);
        return (a + b + c) % 32;
    endfunction

    // One handshake run. sel=0 capture instance, sel=1 live instance.
    // pre=1: start already driven high in the previous done cycle.
    // chain=1: drive start and next first-phase operands in the done cycle.
    task automatic run(input bit sel, input bit pre, input bit chain,
                       input int a1, input int b1, input int c1,
                       input int a2, input int b2, input int c2,
                       input int na, input int nb, input int nc);
        int ea, eb, ec;
        ea = sel ? a2 : a1;
        eb = sel ? b2 : b1;
        ec = sel ? c2 : c1;
        if (!pre) begin
            @(negedge clk);
            ha = a1[DW-1:0]; hb = b1[DW-1:0]; hc = c1[DW+1:0];
            if (sel) st_l = 1'b1; else st_c = 1'b1;
        end
        @(negedge clk); // after edge 0
        st_c = 1'b0; st_l = 1'b0;
        check(pre ? "R7 idle stays low" : "R2 idle low", sel ? l_idle : c_idle, 0);
        check("R3 ready not early", sel ? l_rdy : c_rdy, 0);
        @(negedge clk); // after edge 1
        check("R3 ready pulse", sel ? l_rdy : c_rdy, 1);
        ha = a2[DW-1:0]; hb = b2[DW-1:0]; hc = c2[DW+1:0];
        @(negedge clk); // after edge 2
        check("R3 ready single", sel ? l_rdy : c_rdy, 0);
        check("R4 acc_vld", sel ? l_vld : c_vld, 1);
        check(sel ? "R9 R4 live sum" : "R8 R4 captured sum",
              sel ? int'(l_sum) : int'(c_sum), exp_sum(ea, eb, ec));
        @(negedge clk); // after edge 3
        check("R4 acc_vld single", sel ? l_vld : c_vld, 0);
        check("R5 done", sel ? l_done : c_done, 1);
        check(sel ? "R9 R5 live result" : "R8 R5 captured result",
              sel ? int'(l_ret) : int'(c_ret), ea + eb);
        if (chain) begin
            ha = na[DW-1:0]; hb = nb[DW-1:0]; hc = nc[DW+1:0];
            if (sel) st_l = 1'b1; else st_c = 1'b1;
        end else begin
            ha = '1; hb = '1; hc = '1;
            @(negedge clk); // after edge 4
            check("R6 idle back", sel ? l_idle : c_idle, 1);
            check("R5 done single", sel ? l_done : c_done, 0);
            check("R4 sum held", sel ? int'(l_sum) : int'(c_sum), exp_sum(ea, eb, ec));
            check("R5 result held", sel ? int'(l_ret) : int'(c_ret), ea + eb);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int pa, pb, pc;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1 idle", c_idle, 1);
        check("R1 ready", c_rdy, 0);
        check("R1 done", c_done, 0);
        check("R1 acc_vld", c_vld, 0);
        check("R1 acc_out", c_sum, 0);
        check("R1 result", c_ret, 0);
        check("R1 free vld", f_vld, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", l_idle, 1);
        // R2: no start, stays idle
        repeat (3) @(negedge clk);
        check("R2 no start idle", c_idle, 1);
        check("R2 no start ready", c_rdy, 0);

        // R8 sweep: capture instance, second operand set differs from the first
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int k = 0; k < 3; k++) begin
                    int c = (k == 0) ? 0 : (k == 1) ? 31 : (a * 4 + b + 5) % 32;
                    run(1'b0, 1'b0, 1'b0, a, b, c, 7 - a, b ^ 5, 31 - c, 0, 0, 0);
                end
        // R9 sweep: live instance
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                run(1'b1, 1'b0, 1'b0, 7 - b, a, 3, a, b, (a * 8 + b) % 32, 0, 0, 0);

        // R7: back-to-back runs with start held through the done cycle
        run(1'b0, 1'b0, 1'b1, 7, 7, 31, 0, 0, 0, 5, 6, 20);
        run(1'b0, 1'b1, 1'b1, 5, 6, 20, 1, 1, 1, 2, 3, 4);
        run(1'b0, 1'b1, 1'b0, 2, 3, 4, 6, 6, 6, 0, 0, 0);
        run(1'b1, 1'b0, 1'b1, 1, 2, 3, 4, 5, 9, 0, 0, 0);
        run(1'b1, 1'b1, 1'b0, 3, 3, 3, 7, 1, 30, 0, 0, 0);

        // R10: free-running instance, exhaustive sweep, start toggling
        @(negedge clk);
        pa = 0; pb = 0; pc = 0;
        fa = '0; fb = '0; fc = '0;
        for (int i = 0; i < 8 * 8 * 32; i++) begin
            @(negedge clk);
            check("R10 free sum", f_sum, exp_sum(pa, pb, pc));
            check("R10 free result", f_ret, pa + pb);
            check("R10 free vld", f_vld, 1);
            check("R10 free control low", {f_done, f_rdy, f_idle}, 0);
            pa = i % 8; pb = (i / 8) % 8; pc = (i / 64) % 32;
            fa = pa[DW-1:0]; fb = pb[DW-1:0]; fc = pc[DW+1:0];
            fs = i[0];
        end
        @(negedge clk);
        check("R10 free last sum", f_sum, exp_sum(pa, pb, pc));

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule